// File: doc/BRIEF.md
# S/PDIF Stereo Subframe Transmitter

This block turns a stream of 16-bit stereo PCM pairs into a single biphase-mark serial line in the IEC958 / S/PDIF subframe format. Each stereo pair becomes one frame of two subframes: channel 1 first, then channel 2. Every subframe is 32 slots long. Four preamble slots are sent as eight raw half-cells. The other 28 slots are sent with biphase-mark coding. They carry zero padding, the sample LSB first, and the validity, user, channel-status and parity bits.

PCM pairs arrive on a valid/ready handshake and go into a one-pair holding register. At the start of each frame the held pair is moved into the active pair. If the holding register is empty at that moment, the previous pair is sent again, both subframes of the frame carry a validity bit of 1, and `underrun` is raised for that frame.

Three inputs set the validity and user bits:
- `cfg_override` selects between the defaults and host-supplied values.
- `cfg_vbit` gives the per-channel validity values.
- `cfg_ubit` gives the per-channel user values.

A channel-status vector gives the C bit of each frame in a block of `BLOCK_FRAMES` frames. The frame counter wraps at the end of each block.

The control is one state machine with four states:
- `ST_IDLE`: after reset, waits for the first half-cell tick.
- `ST_PREAMBLE`: sends the eight preamble half-cells.
- `ST_CELL_LEAD`: first half of a data slot.
- `ST_CELL_TRAIL`: second half of a data slot.

Its transitions, all on a half-cell tick:
- idle→preamble: first tick after reset.
- preamble→lead: after the eighth preamble half-cell.
- lead→trail: always.
- trail→lead: when the slot is not slot 31.
- trail→preamble: after slot 31. A new subframe is built and loaded on this transition.

Top module: `spdif_tx`

## Requirements
- R1: While reset is asserted and on the first clock after it, `spdif_out` is 0, `pcm_ready` is 1 and `underrun` is 0.
- R2: Each subframe opens with eight half-cells taken from a preamble code, MSB first.
  - Channel 1 of block frame 0 uses code B: 11101000.
  - Channel 1 of any other frame uses code M: 11100010.
  - Channel 2 always uses code W: 11100100.
  - These values apply when the line level before the preamble is 0. When that level is 1, the bitwise complement of the code is sent.
- R3: Data slots 4 to 11 carry 0. Slots 12 to 27 carry the 16-bit sample, bit 0 in slot 12. Channel 1 carries `pcm_left` and channel 2 carries `pcm_right` of the same pair.
- R4: Slot 28 is V and slot 29 is U. With `cfg_override` low, V is 1 and U is 0. With it high, V is `cfg_vbit[ch]` and U is `cfg_ubit[ch]`, where ch is 0 for channel 1 and 1 for channel 2, sampled when the subframe is loaded.
- R5: Slot 31 makes slots 4 to 31 hold an even number of ones.
- R6: Every half-cell lasts `HALF_DIV` clocks. The line toggles at the start of each data slot, and toggles again at mid-slot exactly when the slot bit is 1.
- R7: Slot 30 of both subframes of block frame n is `chan_status[n]`. After frame `BLOCK_FRAMES-1` the next frame is block frame 0 again, with preamble B.
- R8: `pcm_ready` is high exactly while the holding register is empty. A pair is taken on a clock where `pcm_valid` and `pcm_ready` are both high. The held pair is consumed at the start of the next frame.
- R9: If no pair is held at a frame start, both subframes resend the previous pair with V = 1 and `underrun` is high for that frame. `underrun` clears at the next frame start that finds a held pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pcm_valid | input | 1 | A stereo pair is offered |
| pcm_ready | output | 1 | Holding register empty, pair will be taken |
| pcm_left | input | 16 | Channel 1 sample |
| pcm_right | input | 16 | Channel 2 sample |
| cfg_override | input | 1 | Use host V/U values instead of defaults |
| cfg_vbit | input | 2 | Host validity bit per channel (bit 0 = channel 1) |
| cfg_ubit | input | 2 | Host user bit per channel (bit 0 = channel 1) |
| chan_status | input | BLOCK_FRAMES | Channel-status bit for each frame of a block |
| spdif_out | output | 1 | Biphase-mark serial line, one value per half-cell |
| underrun | output | 1 | Current frame resends the previous pair |

## Verification
The checker assumes three things about the inputs:
- Reset is released away from a clock edge.
- `pcm_valid` and the sample buses change only between edges.
- The host changes `cfg_*` and `chan_status` outside the clock on which a subframe is loaded.

The bench keeps to these by driving every input on the falling edge. It rewrites the V/U configuration only in the middle of a channel-2 subframe, so the value is settled before the next frame loads. Its feeder offers pairs back to back, except for one deliberate pause that starves the holding register for several frames.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;

    localparam int SAMPLE_W    = 16;
    localparam int SLOT_COUNT  = 32;
    localparam int PRE_HALVES  = 8;
    localparam int FIRST_DATA  = 4;
    localparam int SAMPLE_LO   = 12;
    localparam int SAMPLE_HI   = SAMPLE_LO + SAMPLE_W - 1;
    localparam int SLOT_V      = 28;
    localparam int SLOT_U      = 29;
    localparam int SLOT_C      = 30;
    localparam int SLOT_P      = 31;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_CELL_LEAD,
        ST_CELL_TRAIL
    } tx_state_t;

    typedef enum logic [1:0] {
        PRE_BLOCK,
        PRE_LEFT,
        PRE_RIGHT
    } pre_kind_t;

    // Preamble half-cell pattern for a given kind; complemented when the
    // line sits high so the first half-cell always toggles the line.
    function automatic logic [7:0] preamble_code(pre_kind_t kind, logic level);
        logic [7:0] base;
        unique case (kind)
            PRE_BLOCK: base = 8'b1110_1000;
            PRE_LEFT:  base = 8'b1110_0010;
            default:   base = 8'b1110_0100;
        endcase
        return level ? ~base : base;
    endfunction

endpackage

// File: rtl/spdif_cell_timer.sv
module spdif_cell_timer #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic cell_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_q;

    generate
        if (HALF_DIV == 1) begin : g_every
            assign cell_tick = rst_n;
            always_ff @(posedge clk) cnt_q <= '0;
        end else begin : g_div
            assign cell_tick = (cnt_q == CW'(HALF_DIV - 1));
            always_ff @(posedge clk) begin
                if (!rst_n || cell_tick) cnt_q <= '0;
                else                     cnt_q <= cnt_q + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/spdif_pair_buffer.sv
module spdif_pair_buffer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_left,
    input  logic [W-1:0] in_right,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] held_left,
    output logic [W-1:0] held_right
);
    assign in_ready = !full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full       <= 1'b0;
            held_left  <= '0;
            held_right <= '0;
        end else if (in_valid && in_ready) begin
            full       <= 1'b1;
            held_left  <= in_left;
            held_right <= in_right;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/spdif_subframe_builder.sv
module spdif_subframe_builder
    import spdif_tx_pkg::*;
#(
    parameter int BLOCK_FRAMES = 192,
    parameter int FW           = $clog2(BLOCK_FRAMES)
) (
    input  logic                    channel,
    input  logic [FW-1:0]           frame_idx,
    input  logic [SAMPLE_W-1:0]     sample,
    input  logic                    force_v,
    input  logic                    cfg_override,
    input  logic [1:0]              cfg_vbit,
    input  logic [1:0]              cfg_ubit,
    input  logic [BLOCK_FRAMES-1:0] chan_status,
    input  logic                    line_level,
    output logic [SLOT_COUNT-1:0]   word,
    output logic [7:0]              pre_code
);
    pre_kind_t kind;

    always_comb begin
        if (channel)              kind = PRE_RIGHT;
        else if (frame_idx == '0) kind = PRE_BLOCK;
        else                      kind = PRE_LEFT;
        pre_code = preamble_code(kind, line_level);
    end

    always_comb begin
        word = '0;
        word[SAMPLE_HI:SAMPLE_LO] = sample;
        word[SLOT_V] = force_v || !cfg_override || cfg_vbit[channel];
        word[SLOT_U] = cfg_override && cfg_ubit[channel];
        word[SLOT_C] = chan_status[frame_idx];
        word[SLOT_P] = ^word[SLOT_C:FIRST_DATA];
    end
endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
    import spdif_tx_pkg::*;
#(
    parameter int HALF_DIV     = 2,
    parameter int BLOCK_FRAMES = 192
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pcm_valid,
    output logic                    pcm_ready,
    input  logic [15:0]             pcm_left,
    input  logic [15:0]             pcm_right,
    input  logic                    cfg_override,
    input  logic [1:0]              cfg_vbit,
    input  logic [1:0]              cfg_ubit,
    input  logic [BLOCK_FRAMES-1:0] chan_status,
    output logic                    spdif_out,
    output logic                    underrun
);
    localparam int FW        = $clog2(BLOCK_FRAMES);
    localparam int SW        = $clog2(SLOT_COUNT);
    localparam int HW        = $clog2(PRE_HALVES);
    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOT_COUNT - 1);
    localparam logic [HW-1:0] LAST_HALF = HW'(PRE_HALVES - 1);
    localparam logic [FW-1:0] LAST_FRM  = FW'(BLOCK_FRAMES - 1);

    tx_state_t state_q, state_d;

    logic                  cell_tick;
    logic                  buf_full, take;
    logic [SAMPLE_W-1:0]   held_l, held_r;
    logic [SAMPLE_W-1:0]   act_l, act_r;
    logic                  sub_q;
    logic [FW-1:0]         frame_q;
    logic [SW-1:0]         slot_q;
    logic [HW-1:0]         half_q;
    logic [SLOT_COUNT-1:0] word_q;
    logic [7:0]            pre_sh;
    logic                  line_q, underrun_q;

    logic                  boundary, starting_frame, next_ch, force_v;
    logic [FW-1:0]         next_frame;
    logic [SAMPLE_W-1:0]   next_sample;
    logic [SLOT_COUNT-1:0] bld_word;
    logic [7:0]            bld_pre;

    spdif_cell_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cell_tick (cell_tick)
    );

    spdif_pair_buffer #(.W(SAMPLE_W)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (pcm_valid),
        .in_ready   (pcm_ready),
        .in_left    (pcm_left),
        .in_right   (pcm_right),
        .take       (take),
        .full       (buf_full),
        .held_left  (held_l),
        .held_right (held_r)
    );

    // Subframe boundary: leaving idle or finishing the last data slot.
    assign boundary = cell_tick &&
                      ((state_q == ST_IDLE) ||
                       (state_q == ST_CELL_TRAIL && slot_q == LAST_SLOT));
    assign next_ch        = (state_q == ST_IDLE) ? 1'b0 : !sub_q;
    assign starting_frame = boundary && !next_ch;
    assign take           = starting_frame && buf_full;

    always_comb begin
        if (state_q == ST_IDLE)   next_frame = '0;
        else if (!sub_q)          next_frame = frame_q;
        else if (frame_q == LAST_FRM) next_frame = '0;
        else                      next_frame = frame_q + 1'b1;
    end

    always_comb begin
        if (next_ch) begin
            next_sample = act_r;
            force_v     = underrun_q;
        end else begin
            next_sample = buf_full ? held_l : act_l;
            force_v     = !buf_full;
        end
    end

    spdif_subframe_builder #(.BLOCK_FRAMES(BLOCK_FRAMES), .FW(FW)) u_build (
        .channel      (next_ch),
        .frame_idx    (next_frame),
        .sample       (next_sample),
        .force_v      (force_v),
        .cfg_override (cfg_override),
        .cfg_vbit     (cfg_vbit),
        .cfg_ubit     (cfg_ubit),
        .chan_status  (chan_status),
        .line_level   (line_q),
        .word         (bld_word),
        .pre_code     (bld_pre)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (cell_tick) state_d = ST_PREAMBLE;
            ST_PREAMBLE:   if (cell_tick && half_q == LAST_HALF) state_d = ST_CELL_LEAD;
            ST_CELL_LEAD:  if (cell_tick) state_d = ST_CELL_TRAIL;
            ST_CELL_TRAIL: if (cell_tick)
                               state_d = (slot_q == LAST_SLOT) ? ST_PREAMBLE : ST_CELL_LEAD;
            default:       state_d = ST_IDLE;
        endcase
    end

    // Line, subframe and sample registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q     <= 1'b0;
            pre_sh     <= '0;
            word_q     <= '0;
            half_q     <= '0;
            slot_q     <= '0;
            sub_q      <= 1'b0;
            frame_q    <= '0;
            act_l      <= '0;
            act_r      <= '0;
            underrun_q <= 1'b0;
        end else begin
            if (boundary) begin
                line_q  <= bld_pre[7];
                pre_sh  <= {bld_pre[6:0], 1'b0};
                word_q  <= bld_word;
                half_q  <= '0;
                sub_q   <= next_ch;
                frame_q <= next_frame;
            end else if (cell_tick) begin
                unique case (state_q)
                    ST_PREAMBLE: begin
                        if (half_q == LAST_HALF) begin
                            line_q <= !line_q;
                            slot_q <= SW'(FIRST_DATA);
                        end else begin
                            line_q <= pre_sh[7];
                            pre_sh <= {pre_sh[6:0], 1'b0};
                            half_q <= half_q + 1'b1;
                        end
                    end
                    ST_CELL_LEAD: begin
                        if (word_q[slot_q]) line_q <= !line_q;
                    end
                    ST_CELL_TRAIL: begin
                        slot_q <= slot_q + 1'b1;
                        line_q <= !line_q;
                    end
                    default: ;
                endcase
            end
            if (starting_frame) begin
                if (buf_full) begin
                    act_l      <= held_l;
                    act_r      <= held_r;
                    underrun_q <= 1'b0;
                end else begin
                    underrun_q <= 1'b1;
                end
            end
        end
    end

    assign spdif_out = line_q;
    assign underrun  = underrun_q;

endmodule

// File: rtl/spdif_tx_checker.sv
module spdif_tx_checker #(
    parameter int HALF_DIV = 2
) (
    input logic clk,
    input logic rst_n,
    input logic pcm_valid,
    input logic pcm_ready,
    input logic underrun,
    input logic spdif_out
);
    logic        prev_q, seen_q;
    logic [15:0] run_q;

    // Half-cell width: once the line has moved, no level is shorter than HALF_DIV clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            seen_q <= 1'b0;
            run_q  <= '0;
        end else begin
            prev_q <= spdif_out;
            if (spdif_out != prev_q) begin
                if (seen_q) begin
                    assert_cell_min_width_R6: assert (run_q >= 16'(HALF_DIV));
                end
                seen_q <= 1'b1;
                run_q  <= 16'd1;
            end else if (run_q != 16'hFFFF) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (pcm_ready && !underrun && !spdif_out));

    assert_accept_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_valid && pcm_ready) |=> !pcm_ready);

    assert_underrun_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(pcm_ready));

    assert_underrun_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(underrun) |-> !$past(pcm_ready));

endmodule

bind spdif_tx spdif_tx_checker #(.HALF_DIV(HALF_DIV)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .pcm_valid (pcm_valid),
    .pcm_ready (pcm_ready),
    .underrun  (underrun),
    .spdif_out (spdif_out)
);

// File: tb/test_spdif_tx.sv
module test_spdif_tx;
    localparam int HD  = 2;
    localparam int BF  = 192;
    localparam int NFR = BF + 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pcm_valid, pcm_ready;
    logic [15:0]   pcm_left, pcm_right;
    logic          cfg_override;
    logic [1:0]    cfg_vbit, cfg_ubit;
    logic [BF-1:0] chan_status;
    logic          spdif_out, underrun;

    int checks = 0, fails = 0;
    int feed_k = 0, exp_k = 0;
    bit hold_feed = 1'b0;
    logic lvl = 1'b0;
    logic [15:0] last_l = '0, last_r = '0;
    bit cur_ur = 1'b0;
    int ur_pause = 0;

    always #10 clk = ~clk;

    spdif_tx #(.HALF_DIV(HD), .BLOCK_FRAMES(BF)) i_spdif_tx (
        .clk(clk), .rst_n(rst_n), .pcm_valid(pcm_valid), .pcm_ready(pcm_ready),
        .pcm_left(pcm_left), .pcm_right(pcm_right), .cfg_override(cfg_override),
        .cfg_vbit(cfg_vbit), .cfg_ubit(cfg_ubit), .chan_status(chan_status),
        .spdif_out(spdif_out), .underrun(underrun)
    );

    function automatic logic [15:0] smp_l(int k);
        return 16'(k * 40503 + 4660);
    endfunction
    function automatic logic [15:0] smp_r(int k);
        return ~smp_l(k) ^ 16'(k);
    endfunction
    function automatic bit cs_bit(int i);
        return ((i * 5 + 2) % 7) < 3;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic apply_cfg(int j);
        cfg_override = (j >= 100);
        cfg_vbit     = {j[1], j[0]};
        cfg_ubit     = {j[3], j[2]};
    endtask

    task automatic get_half(output logic h);
        repeat (HD) @(posedge clk);
        @(negedge clk);
        h = spdif_out;
    endtask

    task automatic decode_sub(int j, bit ch);
        logic [7:0]  pre, exp_pre;
        logic [31:0] bits;
        logic        h, a, b;
        logic [15:0] exp_s;
        bit          ovr, ev, eu;
        int          bad;
        int          fb;
        fb   = j % BF;
        bits = '0;
        bad  = 0;
        for (int i = 0; i < 8; i++) begin
            get_half(h);
            pre = {pre[6:0], h};
            if (i == 0 && !ch) cur_ur = underrun;
            if (i == 0 && ch) begin
                // R8: feeder runs ahead, so the holding register is full mid-frame
                if (j >= 2 && j < 59) check(pcm_ready == 1'b0, "R8", "ready while held", pcm_ready, 0);
                if (j == 62) check(pcm_ready == 1'b1, "R8", "ready while starved", pcm_ready, 1);
                apply_cfg(j + 1);
                hold_feed = (j + 1 >= 60) && (j + 1 < 64);
            end
        end
        if (ch)            exp_pre = 8'b1110_0100;
        else if (fb == 0)  exp_pre = 8'b1110_1000;
        else               exp_pre = 8'b1110_0010;
        if (lvl) exp_pre = ~exp_pre;
        check(pre == exp_pre, (fb == 0 && !ch) ? "R7" : "R2", "preamble", pre, exp_pre);
        lvl = h;
        for (int s = 4; s < 32; s++) begin
            get_half(a);
            get_half(b);
            if (a == lvl) bad++;
            bits[s] = (a != b);
            lvl = b;
        end
        check(bad == 0, "R6", "missing slot-start toggles", bad, 0);
        check(bits[11:4] == 8'h00, "R3", "padding slots", bits[11:4], 0);
        if (!ch) begin
            if (cur_ur) exp_s = last_l;
            else begin
                exp_s  = smp_l(exp_k);
                last_l = smp_l(exp_k);
                last_r = smp_r(exp_k);
                exp_k++;
            end
            if (cur_ur && j >= 60 && j <= 65) ur_pause++;
            if ((j >= 1 && j < 60) || j > 65)
                check(!cur_ur, "R9", "unexpected underrun", cur_ur, 0);
        end else begin
            exp_s = last_r;
        end
        check(bits[27:12] == exp_s, cur_ur ? "R9" : "R3", "sample", bits[27:12], exp_s);
        ovr = (j >= 100);
        ev  = cur_ur ? 1'b1 : (ovr ? j[ch] : 1'b1);
        eu  = ovr ? j[2 + ch] : 1'b0;
        check(bits[28] == ev, cur_ur ? "R9" : "R4", "V bit", bits[28], ev);
        check(bits[29] == eu, "R4", "U bit", bits[29], eu);
        check(bits[30] == cs_bit(fb), "R7", "C bit", bits[30], cs_bit(fb));
        check(^bits[31:4] == 1'b0, "R5", "parity", ^bits[31:4], 0);
    endtask

    // Pair feeder
    initial begin
        bit acc;
        pcm_valid = 1'b0;
        pcm_left  = '0;
        pcm_right = '0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (hold_feed) pcm_valid = 1'b0;
            else begin
                pcm_valid = 1'b1;
                pcm_left  = smp_l(feed_k);
                pcm_right = smp_r(feed_k);
            end
            acc = pcm_valid && pcm_ready;
            @(posedge clk);
            if (acc) feed_k++;
        end
    end

    initial begin
        rst_n = 1'b0;
        apply_cfg(0);
        for (int i = 0; i < BF; i++) chan_status[i] = cs_bit(i);
        repeat (3) @(negedge clk);
        check(spdif_out == 1'b0, "R1", "line in reset", spdif_out, 0);
        check(pcm_ready == 1'b1, "R1", "ready in reset", pcm_ready, 1);
        check(underrun == 1'b0, "R1", "underrun in reset", underrun, 0);
        rst_n = 1'b1;
        for (int j = 0; j < NFR; j++) begin
            decode_sub(j, 1'b0);
            decode_sub(j, 1'b1);
        end
        check(ur_pause >= 2, "R9", "underruns during pause", ur_pause, 2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule